// File: doc/BRIEF.md
# Two-Wire Converter Result Reader

This block is the host side of a two-wire link to a serial analogue-to-digital converter whose chip select is tied low and whose shift clock comes from the host. No ready pin exists. While a conversion runs, the converter holds its data line high. When the line drops, a result is waiting. The reader watches the data line through a synchroniser. When the line goes low, the reader drives a fixed number of clock pulses and samples one bit on each rising edge, most significant bit first. It then presents the assembled word.

The first bit of every frame is the end-of-conversion flag and must be 0. The second bit tells which input channel produced the result. A frame whose flag reads 1 was started by noise on the line, and it is reported as an error instead of as a result.

The clock line stays low at all times outside a frame. This keeps the converter in its externally clocked mode when it leaves power-on reset. After the last falling edge, the reader waits out the synchroniser latency and then resumes polling.

Top module: `conv_result_reader`

## Requirements
- R1: While `rst_n` is low and after its release, `sck_out`, `result_valid`, `frame_err` and `ready_irq` are 0, and `result_word` and `chan_bit` are 0.
- R2: While the reader is idle with `enable` low, `sck_out` stays low and no frame starts, whatever level `sdo_in` has.
- R3: `sdo_in` passes through SYNC_STAGES flip-flops. With `enable` high and polling, `ready_irq` is high exactly while the synchronised line is low, which is the second clock edge after `sdo_in` falls with the default depth of 2. `sck_out` is low whenever `ready_irq` is high.
- R4: A frame drives exactly FRAME_BITS pulses on `sck_out`. Each low half lasts HALF_LO clocks, counted from the polling edge or from the previous falling edge. Each high half lasts HALF_HI clocks.
- R5: Each bit is taken from the synchronised line on the clock edge where `sck_out` rises. The first bit lands in `result_word[FRAME_BITS-1]` and the last in `result_word[0]`.
- R6: `result_word[FRAME_BITS-1]` is the end-of-conversion flag. `chan_bit` equals the second captured bit, `result_word[FRAME_BITS-2]`.
- R7: When the flag bit is 0, `result_valid` is high for one clock. This happens on the clock after the edge that ends the last high half, and the new `result_word` and `chan_bit` appear in that same clock.
- R8: When the flag bit is 1, `frame_err` pulses for one clock in place of `result_valid`. `result_word` still shows the captured bits.
- R9: After the last falling edge, `sdo_in` is ignored for SYNC_STAGES+1 clocks. Polling then resumes if `enable` is high; otherwise the reader goes idle.
- R10: Dropping `enable` during a frame does not shorten the frame. All pulses are driven and the result is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows polling and new frames |
| sdo_in | input | 1 | Serial data from the converter |
| sck_out | output | 1 | Shift clock to the converter |
| result_word | output | FRAME_BITS (24) | Last captured frame, first bit in the MSB |
| chan_bit | output | 1 | Channel indicator of the last frame |
| result_valid | output | 1 | One-clock strobe for a good frame |
| frame_err | output | 1 | One-clock strobe for a frame whose flag bit was 1 |
| ready_irq | output | 1 | Converter result waiting while polling |

## Verification
The bench builds the reader with HALF_HI=2, HALF_LO=3 and SYNC_STAGES=2, keeping FRAME_BITS at 24. The low half of 3 is the shortest the synchroniser allows. This means every sample is taken on the first edge at which the converter's new bit has cleared both flip-flops, so an off-by-one in the sampling point changes the captured word. Short halves also let the guard window, a glitch-started error frame and a frame interrupted by `enable` all run within a few hundred clocks.

// File: rtl/crr_pkg.sv
package crr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_POLL  = 3'd1,
      ST_LOW   = 3'd2,
      ST_HIGH  = 3'd3,
      ST_GUARD = 3'd4
   } crr_state_e;

   function automatic int crr_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/crr_sync.sv
module crr_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("crr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/crr_half_timer.sv
module crr_half_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             done
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last = limit - 1'b1;
   assign done = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || done)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/crr_shifter.sv
module crr_shifter #(
   parameter int WIDTH = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             din,
   output logic [WIDTH-1:0] word
);

   if (WIDTH < 2) begin : g_bad_width
      $error("crr_shifter: WIDTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[WIDTH-2:0], din};
   end

endmodule

// File: rtl/conv_result_reader.sv
module conv_result_reader
   import crr_pkg::*;
#(
   parameter int FRAME_BITS  = 24,
   parameter int HALF_HI     = 4,
   parameter int HALF_LO     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  sdo_in,
   output logic                  sck_out,
   output logic [FRAME_BITS-1:0] result_word,
   output logic                  chan_bit,
   output logic                  result_valid,
   output logic                  frame_err,
   output logic                  ready_irq
);

   localparam int GUARD_CYC = SYNC_STAGES + 1;
   localparam int MAX_LIM   = crr_max3(HALF_HI, HALF_LO, GUARD_CYC);
   localparam int CNT_W     = $clog2(MAX_LIM + 1);
   localparam int BIT_W     = $clog2(FRAME_BITS + 1);
   localparam int EOC_POS   = FRAME_BITS - 1;
   localparam int CHAN_POS  = FRAME_BITS - 2;

   localparam logic [CNT_W-1:0] LIM_LO    = CNT_W'(HALF_LO);
   localparam logic [CNT_W-1:0] LIM_HI    = CNT_W'(HALF_HI);
   localparam logic [CNT_W-1:0] LIM_GUARD = CNT_W'(GUARD_CYC);
   localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_BITS);

   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("conv_result_reader: FRAME_BITS must hold flag and channel bits");
   end
   if (HALF_HI < 1) begin : g_bad_hi
      $error("conv_result_reader: HALF_HI must be at least 1");
   end
   if (HALF_LO < SYNC_STAGES + 1) begin : g_bad_lo
      $error("conv_result_reader: HALF_LO must cover the synchroniser latency");
   end

   logic             sdo_s;
   crr_state_e       state, state_nx;
   logic             tmr_run, tmr_done;
   logic [CNT_W-1:0] tmr_limit;
   logic [BIT_W-1:0] bit_cnt;
   logic             sck_q;
   logic             shift_en;
   logic             frame_done;
   logic [FRAME_BITS-1:0] word_sh;

   crr_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sdo_in),
      .q     (sdo_s)
   );

   always_comb begin
      tmr_run = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_GUARD);
      unique case (state)
         ST_LOW:  tmr_limit = LIM_LO;
         ST_HIGH: tmr_limit = LIM_HI;
         default: tmr_limit = LIM_GUARD;
      endcase
   end

   crr_half_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tmr_run),
      .limit (tmr_limit),
      .done  (tmr_done)
   );

   assign shift_en   = (state == ST_LOW) && tmr_done;
   assign frame_done = (state == ST_HIGH) && tmr_done && (bit_cnt == LAST_BIT);

   crr_shifter #(
      .WIDTH (FRAME_BITS)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (sdo_s),
      .word     (word_sh)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (enable) state_nx = ST_POLL;
         ST_POLL: begin
            if (!enable)     state_nx = ST_IDLE;
            else if (!sdo_s) state_nx = ST_LOW;
         end
         ST_LOW:   if (tmr_done) state_nx = ST_HIGH;
         ST_HIGH: begin
            if (tmr_done) state_nx = (bit_cnt == LAST_BIT) ? ST_GUARD : ST_LOW;
         end
         ST_GUARD: if (tmr_done) state_nx = enable ? ST_POLL : ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         sck_q   <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_POLL) bit_cnt <= '0;
         else if (shift_en)    bit_cnt <= bit_cnt + 1'b1;
         if (shift_en)                           sck_q <= 1'b1;
         else if ((state == ST_HIGH) && tmr_done) sck_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_word  <= '0;
         chan_bit     <= 1'b0;
         result_valid <= 1'b0;
         frame_err    <= 1'b0;
      end else begin
         result_valid <= frame_done && !word_sh[EOC_POS];
         frame_err    <= frame_done &&  word_sh[EOC_POS];
         if (frame_done) begin
            result_word <= word_sh;
            chan_bit    <= word_sh[CHAN_POS];
         end
      end
   end

   assign sck_out   = sck_q;
   assign ready_irq = (state == ST_POLL) && !sdo_s;

endmodule

// File: rtl/crr_checker.sv
module crr_checker
   import crr_pkg::*;
#(
   parameter int FRAME_BITS = 24,
   parameter int HALF_HI    = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sck_out,
   input logic                  result_valid,
   input logic                  frame_err,
   input logic                  ready_irq,
   input logic [FRAME_BITS-1:0] result_word,
   input logic                  chan_bit,
   input crr_state_e            st
);

   int   hi_run;
   int   n_rise;
   logic sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= 0;
         n_rise <= 0;
         sck_d  <= 1'b0;
      end else begin
         hi_run <= sck_out ? hi_run + 1 : 0;
         sck_d  <= sck_out;
         if (st == ST_POLL)         n_rise <= 0;
         else if (sck_out && !sck_d) n_rise <= n_rise + 1;
      end
   end

   p_idle_sck_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sck_out);

   p_ready_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ready_irq |-> !sck_out);

   p_high_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck_out) |-> (hi_run == HALF_HI));

   p_pulse_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid || frame_err) |-> (n_rise == FRAME_BITS));

   p_chan_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (chan_bit == result_word[FRAME_BITS-2]));

   p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   p_valid_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !result_word[FRAME_BITS-1]);

   p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> (!result_valid && result_word[FRAME_BITS-1]));

endmodule

bind conv_result_reader crr_checker #(
   .FRAME_BITS (FRAME_BITS),
   .HALF_HI    (HALF_HI)
) u_crr_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .sck_out      (sck_out),
   .result_valid (result_valid),
   .frame_err    (frame_err),
   .ready_irq    (ready_irq),
   .result_word  (result_word),
   .chan_bit     (chan_bit),
   .st           (state)
);

// File: tb/test_conv_result_reader.sv
module test_conv_result_reader;

   localparam int CLK_PERIOD = 10;
   localparam int FB = 24;
   localparam int HI = 2;
   localparam int LO = 3;
   localparam int SS = 2;
   localparam int GC = SS + 1;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic sdo = 1'b1;
   logic sck_out, chan_bit, result_valid, frame_err, ready_irq;
   logic [FB-1:0] result_word;

   always #(CLK_PERIOD/2) clk = ~clk;

   conv_result_reader #(
      .FRAME_BITS (FB),
      .HALF_HI    (HI),
      .HALF_LO    (LO),
      .SYNC_STAGES(SS)
   ) i_conv_result_reader (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (en),
      .sdo_in       (sdo),
      .sck_out      (sck_out),
      .result_word  (result_word),
      .chan_bit     (chan_bit),
      .result_valid (result_valid),
      .frame_err    (frame_err),
      .ready_irq    (ready_irq)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- converter model ----------------
   logic [FB-1:0] dv_word, req_word;
   bit dv_active = 0, dv_req = 0, dv_force_low = 0;
   int dv_glitch = 0, dv_falls = 0;
   logic dv_prev = 1'b0;

   always @(negedge clk) begin
      if (dv_active) begin
         if (dv_prev && !sck_out) begin
            dv_falls++;
            if (dv_falls == FB) begin
               sdo = 1'b1;
               dv_active = 0;
            end else begin
               sdo = dv_word[FB-1-dv_falls];
            end
         end
      end else if (dv_req) begin
         dv_word = req_word;
         dv_active = 1;
         dv_falls = 0;
         sdo = req_word[FB-1];
         dv_req = 0;
      end else if (dv_glitch > 0) begin
         sdo = 1'b0;
         dv_glitch--;
      end else if (dv_force_low) begin
         sdo = 1'b0;
      end else begin
         sdo = 1'b1;
      end
      dv_prev = sck_out;
   end

   // ---------------- reference model ----------------
   int m_ph = 0;            // 0 idle 1 poll 2 low 3 high 4 guard
   int m_cnt = 0, m_bits = 0;
   logic [SS-1:0] m_syn = '1;
   logic [FB-1:0] m_word = '0, m_res = '0;
   logic m_sck = 0, m_valid = 0, m_err = 0, m_chan = 0;
   logic m_ready = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_bits = 0; m_syn = '1;
         m_word = '0; m_res = '0; m_sck = 0; m_valid = 0; m_err = 0; m_chan = 0;
      end else begin
         m_valid = 0;
         m_err = 0;
         case (m_ph)
            0: if (en) m_ph = 1;
            1: begin
               if (!en) m_ph = 0;
               else if (m_syn[SS-1] == 1'b0) begin m_ph = 2; m_cnt = 0; m_bits = 0; end
            end
            2: begin
               if (m_cnt == LO - 1) begin
                  m_sck = 1; m_word = {m_word[FB-2:0], m_syn[SS-1]};
                  m_bits++; m_cnt = 0; m_ph = 3;
               end else m_cnt++;
            end
            3: begin
               if (m_cnt == HI - 1) begin
                  m_sck = 0; m_cnt = 0;
                  if (m_bits == FB) begin
                     m_ph = 4; m_res = m_word; m_chan = m_word[FB-2];
                     if (m_word[FB-1]) m_err = 1; else m_valid = 1;
                  end else m_ph = 2;
               end else m_cnt++;
            end
            default: begin
               if (m_cnt == GC - 1) begin m_cnt = 0; m_ph = en ? 1 : 0; end
               else m_cnt++;
            end
         endcase
         m_syn = {m_syn[SS-2:0], sdo};
      end
      m_ready = (m_ph == 1) && (m_syn[SS-1] == 1'b0);
   end

   // ---------------- per-clock compare and frame scoreboard ----------------
   logic [FB-1:0] expq[$];
   int exp_err = 0;

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
         finish_run();
      end
      chk(sck_out === m_sck, "R4", "sck_out", sck_out, m_sck);
      chk(result_valid === m_valid, "R7", "result_valid", result_valid, m_valid);
      chk(frame_err === m_err, "R8", "frame_err", frame_err, m_err);
      chk(ready_irq === m_ready, "R3", "ready_irq", ready_irq, m_ready);
      chk(result_word === m_res, "R5", "result_word", result_word, m_res);
      chk(chan_bit === m_chan, "R6", "chan_bit", chan_bit, m_chan);
      if (result_valid) begin
         if (expq.size() == 0) chk(0, "R7", "valid with no frame sent", 1, 0);
         else begin
            logic [FB-1:0] e;
            e = expq.pop_front();
            chk(result_word === e, "R5", "frame word", result_word, e);
            chk(chan_bit === e[FB-2], "R6", "channel bit", chan_bit, e[FB-2]);
         end
      end
      if (frame_err) begin
         chk(exp_err > 0, "R8", "unexpected error frame", 1, 0);
         chk(result_word === '1, "R8", "error frame word", result_word, {FB{1'b1}});
         if (exp_err > 0) exp_err--;
      end
   end

   // ---------------- stimulus ----------------
   task automatic send(input logic [FB-1:0] w, input bit check_ready);
      repeat (GC + 3) @(negedge clk);
      @(posedge clk);
      req_word = w;
      dv_req = 1;
      expq.push_back(w);
      if (check_ready) begin
         @(negedge clk);
         chk(ready_irq == 1'b0, "R3", "ready before sync", ready_irq, 0);
         @(negedge clk);
         chk(ready_irq == 1'b0, "R3", "ready after one stage", ready_irq, 0);
         @(negedge clk);
         chk(ready_irq == 1'b1, "R3", "ready after two stages", ready_irq, 1);
      end
   endtask

   task automatic wait_result();
      int n;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(result_valid || frame_err) && n < 3000);
      chk(n < 3000, "R7", "frame result timeout", n, 3000);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(sck_out == 0, "R1", "sck in reset", sck_out, 0);
      chk(result_valid == 0 && frame_err == 0, "R1", "strobes in reset", {result_valid, frame_err}, 0);
      chk(ready_irq == 0, "R1", "ready in reset", ready_irq, 0);
      chk(result_word == '0 && chan_bit == 0, "R1", "word in reset", result_word, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sck_out == 0, "R1", "sck after release", sck_out, 0);

      // R2: line low while disabled must not start a frame
      @(posedge clk);
      dv_force_low = 1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         chk(sck_out == 0 && ready_irq == 0, "R2", "idle with line low", {sck_out, ready_irq}, 0);
      end
      @(posedge clk);
      dv_force_low = 0;
      repeat (4) @(negedge clk);
      en = 1'b1;

      // R5 R6 R7: several patterns
      send(24'h3A5C96, 1); wait_result();
      send(24'h400001, 1); wait_result();
      send(24'h7FFFFF, 1); wait_result();
      send(24'h000000, 1); wait_result();
      send(24'h555555, 1); wait_result();

      // R8: a short low glitch starts a frame whose flag reads 1
      repeat (GC + 3) @(negedge clk);
      @(posedge clk);
      exp_err++;
      dv_glitch = 2;
      wait_result();
      chk(result_valid == 0, "R8", "no valid on error frame", result_valid, 0);

      // R9: back to back frames after the guard window
      send(24'h12AB34, 1); wait_result();

      // R10: enable drops mid-frame, frame still completes
      send(24'h2B00F1, 0);
      repeat (20) @(negedge clk);
      en = 1'b0;
      wait_result();
      repeat (GC + 2) @(negedge clk);
      // R9 then R2: reader now idle, ignores a waiting result
      @(posedge clk);
      req_word = 24'h6C3D0E;
      dv_req = 1;
      expq.push_back(24'h6C3D0E);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk(sck_out == 0, "R9", "idle after disabled frame", sck_out, 0);
      end
      en = 1'b1;
      wait_result();

      repeat (10) @(negedge clk);
      chk(expq.size() == 0, "R7", "frames left unreported", expq.size(), 0);
      chk(exp_err == 0, "R8", "error frames missing", exp_err, 0);
      finish_run();
   end

endmodule